// File: doc/BRIEF.md
# Flash Command and Interrupt Register Front End

This unit is the host-facing register layer of a NAND-style flash controller. The host uses a single-cycle register port to program eight start-address words, a buffer-select word, two configuration words and a command word. The same port reads back controller status, interrupt status and three fixed identification words. Reads are combinational on the address.

An accepted array command is handed to a separate array engine. The unit sends a one-cycle strobe that carries the opcode, the buffer number and the sector count. It then holds the ready pin low until the engine answers with a done pulse and an error flag. Three kinds of command are handled inside the unit itself: immediate ones, reset commands (which perform a warm reset) and unknown codes.

The unit owns the error and interrupt bookkeeping. Interrupt flags are cleared by AND-writes, and clearing the master flag also wipes the error flags. While the master flag is set, further commands are refused. The interrupt pin polarity comes from a configuration bit.

Top module: `fcmd_regs`

## Requirements
- R1: After the asynchronous reset, the registers read as follows: configuration-1 = 0x40C0, configuration-2 = 0x0000, interrupt status = 0x8080, controller status = 0x0000. Both rdy_o and irq_o are 1.
- R2: irq_o equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6.
- R3: A write to interrupt status (offset 0x31) ANDs the written value into it. If bit 15 is clear after the AND, error bits 10 to 13 of controller status (offset 0x30) are cleared. Otherwise they are kept.
- R4: A command write (offset 0x20) is ignored while interrupt bit 15 is set or an engine command is outstanding. In that case no strobe is sent and the command register keeps its old value.
- R5: Engine-class opcodes are 0x00 and 0x13 (load), 0x80, 0x1A and 0x1B (program), 0x94 and 0x95 (erase), and 0x23, 0x27, 0x2A, 0x2C, 0x65 and 0x71 (protection). An accepted engine-class opcode raises cmd_strobe_o for exactly one cycle, in the cycle after the write. The strobe carries the opcode, the buffer number and the sector count. rdy_o is 0 from the strobe until the cycle after the engine's done pulse.
- R6: When the engine finishes, interrupt bit 15 is set together with a done bit for the class: load sets bit 7, program sets bit 6, erase sets bit 5, and protection sets no extra bit. If the engine reports an error, status bit 10 is set together with an error bit for the class: load sets bit 13, program sets bit 12, erase sets bit 11, and protection sets none.
- R7: Any opcode that is not listed sets status bit 10 and interrupt bit 15 in the cycle after the write, and no strobe is sent.
- R8: Opcodes 0xF0 and 0xF3 perform a warm reset. Start addresses, configuration-2, the command register and status are cleared. Configuration-1 becomes 0x40C0, the buffer-select word reads 0x0001, interrupt status becomes 0x8010, and rdy_o becomes 1.
- R9: Configuration-1 (offset 0x21) reads back masked with 0xFFE0. When it is written while no engine command is outstanding, rdy_o takes the written bit 7.
- R10: The buffer-select word (offset 0x10) takes the buffer number from bits 11:8 and the raw count from bits 1:0. A raw count of 0 means 4 sectors. The word reads back as these two fields.
- R11: Opcode 0x30 sets interrupt bits 15 and 5 at once. Opcode 0xB0 is accepted into the command register but changes no interrupt or status bit and sends no strobe.
- R12: The start addresses (offsets 0x00 to 0x07) and configuration-2 (offset 0x22) read back what was written. The identification words at offsets 0x38, 0x39 and 0x3A return the MFR_ID, DEV_ID and VER_ID parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| cmd_strobe_o | output | 1 | One-cycle command launch to the engine |
| cmd_code_o | output | 16 | Latched opcode |
| cmd_buf_o | output | 4 | Buffer number |
| cmd_cnt_o | output | 3 | Sector count, 1 to 4 |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_err_i | input | 1 | Engine error, valid with eng_done_i |
| irq_o | output | 1 | Interrupt pin |
| rdy_o | output | 1 | Ready pin |

## Verification
The assertions assume three things about the engine. It pulses eng_done_i for a single cycle. It does so only after a strobe it has received. It never answers in the same cycle as the strobe. A done pulse that arrives with nothing outstanding is discarded, and the properties stay valid in that case. The bench's engine stub answers every strobe once, after a fixed latency of several cycles. The bench issues at most one register write per cycle and always waits for rdy_o before it moves on, so no command ever overlaps an outstanding one.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_SADDR = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_BSEL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CFG1  = 8'h21;
  localparam logic [ADDR_W-1:0] OFS_CFG2  = 8'h22;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_INT   = 8'h31;
  localparam logic [ADDR_W-1:0] OFS_MFR   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_DEV   = 8'h39;
  localparam logic [ADDR_W-1:0] OFS_VER   = 8'h3A;

  localparam int IB_MASTER = 15;
  localparam int IB_LOAD   = 7;
  localparam int IB_PROG   = 6;
  localparam int IB_ERASE  = 5;
  localparam int EB_CMD    = 10;
  localparam int EB_ERASE  = 11;
  localparam int EB_PROG   = 12;
  localparam int EB_LOAD   = 13;

  localparam logic [DATA_W-1:0] ERR_MASK  = 16'h3C00;
  localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;
  localparam logic [DATA_W-1:0] CFG1_RST  = 16'h40C0;
  localparam logic [DATA_W-1:0] CFG1_RMSK = 16'hFFE0;

  typedef enum logic [2:0] {
    CL_LOAD, CL_PROG, CL_ERASE, CL_PROT, CL_RESUME, CL_NOP, CL_RESET, CL_BAD
  } cmd_class_e;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
(
  input  logic [DATA_W-1:0] code_i,
  output cmd_class_e        cls_o,
  output logic              eng_o
);
  always_comb begin
    cls_o = CL_BAD;
    if (code_i[15:8] == 8'h00) begin
      unique case (code_i[7:0])
        8'h00, 8'h13:               cls_o = CL_LOAD;
        8'h80, 8'h1A, 8'h1B:        cls_o = CL_PROG;
        8'h94, 8'h95:               cls_o = CL_ERASE;
        8'h23, 8'h27, 8'h2A,
        8'h2C, 8'h65, 8'h71:        cls_o = CL_PROT;
        8'h30:                      cls_o = CL_RESUME;
        8'hB0:                      cls_o = CL_NOP;
        8'hF0, 8'hF3:               cls_o = CL_RESET;
        default:                    cls_o = CL_BAD;
      endcase
    end
  end

  assign eng_o = (cls_o == CL_LOAD) || (cls_o == CL_PROG) ||
                 (cls_o == CL_ERASE) || (cls_o == CL_PROT);
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       warm_i,
  input  logic       launch_i,
  input  cmd_class_e cls_i,
  input  logic       done_i,
  input  logic       cfg_wr_i,
  input  logic       cfg_rdy_i,
  output logic       strobe_o,
  output logic       busy_o,
  output logic       fin_o,
  output cmd_class_e fin_cls_o,
  output logic       rdy_o
);
  logic       strobe_q, busy_q, rdy_q;
  cmd_class_e cls_q;

  assign fin_o     = done_i && busy_q;
  assign fin_cls_o = cls_q;
  assign strobe_o  = strobe_q;
  assign busy_o    = busy_q;
  assign rdy_o     = rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
      rdy_q    <= 1'b1;
      cls_q    <= CL_NOP;
    end else begin
      strobe_q <= launch_i;
      if (warm_i) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
      end else if (launch_i) begin
        busy_q <= 1'b1;
        rdy_q  <= 1'b0;
        cls_q  <= cls_i;
      end else if (fin_o) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
      end else if (cfg_wr_i && !busy_q) begin
        rdy_q  <= cfg_rdy_i;
      end
    end
  end
endmodule

// File: rtl/fcmd_irq.sv
module fcmd_irq
  import fcmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_i,
  input  logic              int_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] set_int_i,
  input  logic [DATA_W-1:0] set_err_i,
  input  logic              pol_i,
  output logic [DATA_W-1:0] int_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] int_q, stat_q, int_and, int_d, stat_d;

  always_comb begin
    int_and = int_wr_i ? (int_q & wdata_i) : int_q;
    int_d   = int_and | set_int_i;
    stat_d  = stat_q;
    // dropping the master flag wipes pending error flags
    if (int_wr_i && !int_and[IB_MASTER]) stat_d = stat_d & ~ERR_MASK;
    stat_d  = stat_d | set_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (warm_i) begin
      int_q  <= INT_WARM;
      stat_q <= '0;
    end else begin
      int_q  <= int_d;
      stat_q <= stat_d;
    end
  end

  assign int_o  = int_q;
  assign stat_o = stat_q;
  assign irq_o  = int_q[IB_MASTER] ^ ~pol_i;
endmodule

// File: rtl/fcmd_regs.sv
module fcmd_regs
  import fcmd_pkg::*;
#(
  parameter int                NUM_SADDR = 8,
  parameter int                BUF_W     = 4,
  parameter int                SECT_W    = 2,
  parameter logic [DATA_W-1:0] MFR_ID    = 16'h00EC,
  parameter logic [DATA_W-1:0] DEV_ID    = 16'h0048,
  parameter logic [DATA_W-1:0] VER_ID    = 16'h0031,
  localparam int               CNT_W     = SECT_W + 1,
  localparam int               SIDX_W    = $clog2(NUM_SADDR),
  localparam int               BUF_LSB   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cmd_strobe_o,
  output logic [DATA_W-1:0] cmd_code_o,
  output logic [BUF_W-1:0]  cmd_buf_o,
  output logic [CNT_W-1:0]  cmd_cnt_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  output logic              irq_o,
  output logic              rdy_o
);
  logic [DATA_W-1:0] saddr_q [NUM_SADDR];
  logic [DATA_W-1:0] cfg1_q, cfg2_q, cmd_q, int_q, stat_q;
  logic [BUF_W-1:0]  buf_q;
  logic [SECT_W-1:0] cnt_raw_q;

  logic       wr_cmd, wr_cfg1, wr_cfg2, wr_bsel, wr_int, wr_sa;
  logic       accept, launch, warm, is_eng, busy, fin;
  cmd_class_e cls, fin_cls;
  logic [DATA_W-1:0] set_int, set_err;

  assign wr_sa   = reg_we_i && (reg_addr_i < OFS_SADDR + ADDR_W'(NUM_SADDR));
  assign wr_bsel = reg_we_i && (reg_addr_i == OFS_BSEL);
  assign wr_cmd  = reg_we_i && (reg_addr_i == OFS_CMD);
  assign wr_cfg1 = reg_we_i && (reg_addr_i == OFS_CFG1);
  assign wr_cfg2 = reg_we_i && (reg_addr_i == OFS_CFG2);
  assign wr_int  = reg_we_i && (reg_addr_i == OFS_INT);

  fcmd_decode u_dec (.code_i(reg_wdata_i), .cls_o(cls), .eng_o(is_eng));

  assign accept = wr_cmd && !int_q[IB_MASTER] && !busy;
  assign launch = accept && is_eng;
  assign warm   = accept && (cls == CL_RESET);

  fcmd_seq u_seq (
    .clk_i, .rst_ni, .warm_i(warm), .launch_i(launch), .cls_i(cls),
    .done_i(eng_done_i), .cfg_wr_i(wr_cfg1), .cfg_rdy_i(reg_wdata_i[7]),
    .strobe_o(cmd_strobe_o), .busy_o(busy), .fin_o(fin), .fin_cls_o(fin_cls),
    .rdy_o
  );

  // event bits: immediate opcodes and engine completion never coincide
  always_comb begin
    set_int = '0;
    set_err = '0;
    if (accept && cls == CL_RESUME) begin
      set_int[IB_MASTER] = 1'b1;
      set_int[IB_ERASE]  = 1'b1;
    end
    if (accept && cls == CL_BAD) begin
      set_int[IB_MASTER] = 1'b1;
      set_err[EB_CMD]    = 1'b1;
    end
    if (fin) begin
      set_int[IB_MASTER] = 1'b1;
      set_err[EB_CMD]    = eng_err_i;
      unique case (fin_cls)
        CL_LOAD:  begin set_int[IB_LOAD]  = 1'b1; set_err[EB_LOAD]  = eng_err_i; end
        CL_PROG:  begin set_int[IB_PROG]  = 1'b1; set_err[EB_PROG]  = eng_err_i; end
        CL_ERASE: begin set_int[IB_ERASE] = 1'b1; set_err[EB_ERASE] = eng_err_i; end
        default:  ;
      endcase
    end
  end

  fcmd_irq u_irq (
    .clk_i, .rst_ni, .warm_i(warm), .int_wr_i(wr_int), .wdata_i(reg_wdata_i),
    .set_int_i(set_int), .set_err_i(set_err), .pol_i(cfg1_q[6]),
    .int_o(int_q), .stat_o(stat_q), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || warm) begin
      for (int i = 0; i < NUM_SADDR; i++) saddr_q[i] <= '0;
      cfg1_q    <= CFG1_RST;
      cfg2_q    <= '0;
      cmd_q     <= '0;
      buf_q     <= '0;
      cnt_raw_q <= SECT_W'(1);
    end else begin
      if (wr_sa) saddr_q[reg_addr_i[SIDX_W-1:0]] <= reg_wdata_i;
      if (wr_cfg1) cfg1_q <= reg_wdata_i;
      if (wr_cfg2) cfg2_q <= reg_wdata_i;
      if (accept)  cmd_q  <= reg_wdata_i;
      if (wr_bsel) begin
        buf_q     <= reg_wdata_i[BUF_LSB +: BUF_W];
        cnt_raw_q <= reg_wdata_i[SECT_W-1:0];
      end
    end
  end

  assign cmd_code_o = cmd_q;
  assign cmd_buf_o  = buf_q;
  assign cmd_cnt_o  = (cnt_raw_q == '0) ? CNT_W'(1 << SECT_W) : CNT_W'(cnt_raw_q);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < OFS_SADDR + ADDR_W'(NUM_SADDR)) begin
      reg_rdata_o = saddr_q[reg_addr_i[SIDX_W-1:0]];
    end else begin
      unique case (reg_addr_i)
        OFS_BSEL: begin
          reg_rdata_o[BUF_LSB +: BUF_W] = buf_q;
          reg_rdata_o[SECT_W-1:0]       = cnt_raw_q;
        end
        OFS_CMD:  reg_rdata_o = cmd_q;
        OFS_CFG1: reg_rdata_o = cfg1_q & CFG1_RMSK;
        OFS_CFG2: reg_rdata_o = cfg2_q;
        OFS_STAT: reg_rdata_o = stat_q;
        OFS_INT:  reg_rdata_o = int_q;
        OFS_MFR:  reg_rdata_o = MFR_ID;
        OFS_DEV:  reg_rdata_o = DEV_ID;
        OFS_VER:  reg_rdata_o = VER_ID;
        default:  reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcmd_regs_chk.sv
module fcmd_regs_chk
  import fcmd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              wdata_master,
  input logic              eng_done_i,
  input logic              cmd_strobe_o,
  input logic              rdy_o,
  input logic              int_master,
  input logic [3:0]        err_bits,
  input logic              busy
);
  // R5: launch pulse is one cycle wide
  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_o |=> !cmd_strobe_o);

  // R5: ready is low while a launch is on the wire
  a_r5_not_ready_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_o |-> !rdy_o);

  // R4: pending master flag blocks launches
  a_r4_refuse_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_CMD && int_master) |=> !cmd_strobe_o);

  // R3: master clear wipes errors
  a_r3_master_clear_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_INT && !wdata_master && !(eng_done_i && busy))
      |=> (err_bits == 4'b0000));

  // R6: completion raises master flag and ready
  a_r6_done_sets_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && busy) |=> (int_master && rdy_o));

  // R4: no launch leaves while master flag is up
  a_r4_no_strobe_when_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_o |-> !int_master);
endmodule

bind fcmd_regs fcmd_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .wdata_master(reg_wdata_i[15]), .eng_done_i(eng_done_i),
  .cmd_strobe_o(cmd_strobe_o), .rdy_o(rdy_o), .int_master(int_q[15]),
  .err_bits(stat_q[13:10]), .busy(busy)
);

// File: tb/fcmd_regs_tb.sv
`timescale 1ns/1ps
module fcmd_regs_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        strobe;
  logic [15:0] code;
  logic [3:0]  bufn;
  logic [2:0]  cnt;
  logic        done = 1'b0;
  logic        err = 1'b0;
  logic        irq, rdy;
  logic        err_cfg = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [22:0] exp_q[$];

  always #2 clk = ~clk;

  fcmd_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_strobe_o(strobe),
    .cmd_code_o(code), .cmd_buf_o(bufn), .cmd_cnt_o(cnt),
    .eng_done_i(done), .eng_err_i(err), .irq_o(irq), .rdy_o(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] e, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == e, req, rdata, e);
  endtask

  task automatic expect_cmd(input logic [15:0] c, input logic [3:0] b, input logic [2:0] n);
    exp_q.push_back({c, b, n});
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rdy) break;
    end
  endtask

  // engine stub
  initial begin
    forever begin
      @(negedge clk);
      if (strobe) begin
        repeat (LAT - 1) @(negedge clk);
        done = 1'b1; err = err_cfg;
        @(negedge clk);
        done = 1'b0; err = 1'b0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && strobe) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected strobe (R4/R7/R11)", code, 0);
        end else begin
          logic [22:0] e;
          e = exp_q.pop_front();
          chk({code, bufn, cnt} == e, "R5 strobe fields", {code, bufn, cnt}, e);
          chk(rdy == 1'b0, "R5 ready low on strobe", rdy, 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_chk(8'h21, 16'h40C0, "R1 cfg1");
    rd_chk(8'h22, 16'h0000, "R1 cfg2");
    rd_chk(8'h31, 16'h8080, "R1 int");
    rd_chk(8'h30, 16'h0000, "R1 stat");
    chk(rdy == 1'b1, "R1 rdy", rdy, 1);
    chk(irq == 1'b1, "R1 irq", irq, 1);

    rd_chk(8'h38, 16'h00EC, "R12 mfr");
    rd_chk(8'h39, 16'h0048, "R12 dev");
    rd_chk(8'h3A, 16'h0031, "R12 ver");
    wr(8'h03, 16'hBEEF);
    wr(8'h22, 16'h1234);
    rd_chk(8'h03, 16'hBEEF, "R12 saddr");
    rd_chk(8'h22, 16'h1234, "R12 cfg2");

    // refused while master set
    wr(8'h20, 16'h0080);
    repeat (3) @(negedge clk);
    rd_chk(8'h20, 16'h0000, "R4 cmd kept");

    // AND clear
    wr(8'h31, 16'h0000);
    rd_chk(8'h31, 16'h0000, "R3 int cleared");
    chk(irq == 1'b0, "R2 irq low", irq, 0);

    // buffer select
    wr(8'h10, 16'h0A02);
    rd_chk(8'h10, 16'h0A02, "R10 bsel readback");
    wr(8'h10, 16'h0500);
    rd_chk(8'h10, 16'h0500, "R10 bsel zero count");

    // load, no error: count 0 means 4
    expect_cmd(16'h0000, 4'h5, 3'd4);
    wr(8'h20, 16'h0000);
    chk(rdy == 1'b0, "R5 ready low after launch", rdy, 0);
    wait_rdy();
    rd_chk(8'h31, 16'h8080, "R6 load done");
    rd_chk(8'h30, 16'h0000, "R6 load no err");
    wr(8'h31, 16'h0000);

    // program with error
    err_cfg = 1'b1;
    wr(8'h10, 16'h0301);
    expect_cmd(16'h0080, 4'h3, 3'd1);
    wr(8'h20, 16'h0080);
    wait_rdy();
    rd_chk(8'h31, 16'h8040, "R6 prog done");
    rd_chk(8'h30, 16'h1400, "R6 prog err");
    wr(8'h31, 16'h7FFF);
    rd_chk(8'h31, 16'h0040, "R3 and-write");
    rd_chk(8'h30, 16'h0000, "R3 errors wiped");
    wr(8'h31, 16'h0000);

    // erase with error, master kept
    expect_cmd(16'h0094, 4'h3, 3'd1);
    wr(8'h20, 16'h0094);
    wait_rdy();
    rd_chk(8'h31, 16'h8020, "R6 erase done");
    rd_chk(8'h30, 16'h0C00, "R6 erase err");
    wr(8'h31, 16'h8000);
    rd_chk(8'h31, 16'h8000, "R3 master kept");
    rd_chk(8'h30, 16'h0C00, "R3 errors kept");
    wr(8'h31, 16'h0000);
    err_cfg = 1'b0;

    // unknown opcode
    wr(8'h20, 16'h0055);
    rd_chk(8'h31, 16'h8000, "R7 int");
    rd_chk(8'h30, 16'h0400, "R7 stat");
    wr(8'h31, 16'h0000);

    // resume / suspend
    wr(8'h20, 16'h0030);
    rd_chk(8'h31, 16'h8020, "R11 resume");
    wr(8'h31, 16'h0000);
    wr(8'h20, 16'h00B0);
    repeat (3) @(negedge clk);
    rd_chk(8'h31, 16'h0000, "R11 suspend int");
    rd_chk(8'h20, 16'h00B0, "R11 suspend cmd");

    // configuration-1: polarity, ready, read mask
    wr(8'h21, 16'h0000);
    rd_chk(8'h21, 16'h0000, "R9 cfg1 zero");
    chk(rdy == 1'b0, "R9 rdy follows bit7", rdy, 0);
    chk(irq == 1'b1, "R2 irq inverted polarity", irq, 1);
    wr(8'h21, 16'hFFFF);
    rd_chk(8'h21, 16'hFFE0, "R9 cfg1 mask");
    chk(rdy == 1'b1, "R9 rdy high", rdy, 1);
    chk(irq == 1'b0, "R2 irq normal polarity", irq, 0);

    // protection class
    expect_cmd(16'h002A, 4'h3, 3'd1);
    wr(8'h20, 16'h002A);
    wait_rdy();
    rd_chk(8'h31, 16'h8000, "R6 prot done");
    chk(irq == 1'b1, "R2 irq on master", irq, 1);
    wr(8'h31, 16'h0000);

    // warm reset
    wr(8'h00, 16'h0055);
    wr(8'h20, 16'h00F0);
    rd_chk(8'h31, 16'h8010, "R8 int");
    rd_chk(8'h21, 16'h40C0, "R8 cfg1");
    rd_chk(8'h22, 16'h0000, "R8 cfg2");
    rd_chk(8'h00, 16'h0000, "R8 saddr");
    rd_chk(8'h30, 16'h0000, "R8 stat");
    rd_chk(8'h10, 16'h0001, "R8 bsel");
    chk(rdy == 1'b1, "R8 rdy", rdy, 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all launches seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule